// File: doc/BRIEF.md
# Segmented Inverse-CDF Linear Interpolator

This block turns a uniform random sample that arrives in split floating-point form into a Gaussian-distributed signed fixed-point value. The sample has three parts: a half-select bit, an exponent and a mantissa. The block evaluates a piecewise-linear approximation of the inverse normal CDF. It does no floating-point arithmetic. The exponent names a power-of-two segment of the interval (0, 0.5). Segments grow twice as wide with each step away from zero, so the steep tail gets the finest coverage. The top three mantissa bits split each segment into eight equal subsegments. Each subsegment has its own offset and slope in a coefficient table.

The table address is formed by placing the exponent above the three subsegment bits, so no leading-zero count or shifter is needed. The coefficient pair read from that address is combined with the remaining mantissa bits, taken as an unsigned integer, in a registered multiply and accumulate. A window of the sum is taken as the result. Samples from the upper half of (0, 1) use the odd symmetry of the distribution: the block negates the result in two's complement.

The table is filled through a write-only load port before sampling starts. After that the block accepts one sample every cycle with no stall. Each result appears a fixed four cycles later, marked by a valid flag.

Top module: `icdf_interp`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid is 0 and out_y is 0.
- R2: The coefficient address of a sample is {in_exp, in_mant[MANT_W-1 -: 3]}, 9 bits by default, with the exponent in the high bits. Address 0 and address 511 both select their own entries.
- R3: With x = in_mant[MANT_W-4:0] taken as unsigned, the block computes acc = c0 + c1*x in ACC_W bits. The value field is then acc[FRAC_SHIFT +: OUT_W], which is acc shifted right by FRAC_SHIFT with the upper bits truncated.
- R4: c0 (ld_off) and c1 (ld_slope) are signed two's complement values, so a negative slope lowers the result as x grows.
- R5: When in_neg is 1, out_y is the two's complement negation (modulo 2^OUT_W) of the value field. The field is truncated before it is negated, so the result is exactly the negation of the in_neg = 0 result for the same exponent and mantissa.
- R6: A sample taken with in_valid at a clock edge produces out_valid and its out_y after exactly four clock edges. On the cycle before that, out_valid is 0.
- R7: Samples can be supplied on consecutive cycles with no stall. Their results come out in order on consecutive cycles.
- R8: A write with ld_we = 1 is used by every later sample at that address. Values on ld_addr, ld_off and ld_slope while ld_we = 0 leave the table unchanged.
- R9: Whenever out_valid is 0, out_y is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_we | input | 1 | Table write enable |
| ld_addr | input | EXP_W+SUB_W (9) | Table write address |
| ld_off | input | C0_W (46) | Signed offset c0 to write |
| ld_slope | input | C1_W (23) | Signed slope c1 to write |
| in_valid | input | 1 | Sample present this cycle |
| in_neg | input | 1 | Half select: 1 negates the result |
| in_exp | input | EXP_W (6) | Exponent (segment index) |
| in_mant | input | MANT_W (20) | Mantissa without hidden bit |
| out_valid | output | 1 | Result present this cycle |
| out_y | output | OUT_W (24) | Signed fixed-point result |

## Verification
The bench checks the two ends of the address space: exponent 0 with subsegment 0, and exponent 63 with all mantissa bits set. If the exponent and subsegment bits were swapped or misplaced in the address, these samples would read the wrong table entries and give wrong values. It sends the same exponent and mantissa with both half bits and requires an exact two's complement match. A design that negated before truncating, or used ones' complement, would be off by one there. Mantissa operands of zero and of all ones, together with negative slopes and offsets, catch an operand treated as signed or a product not sign-extended. A back-to-back stream, a load with the enable low, and single samples checked one cycle early and one cycle late catch a wrong latency, a valid flag out of step with its data, and writes that leak through.

// File: rtl/icdf_pkg.sv
// Package: shared constants for the inverse-CDF interpolator.
// Assumes: the pipeline depth is fixed by the stage structure in icdf_interp.
package icdf_pkg;
    // Number of clock edges from an accepted sample to its result.
    localparam int LATENCY = 4;
    // Number of mantissa bits that choose the subsegment.
    localparam int SUBSEG_BITS = 3;
endpackage

// File: rtl/icdf_coef_ram.sv
// Module: icdf_coef_ram
// Coefficient table holding an offset and a slope per subsegment.
// It has one synchronous write port and one registered read port.
// Assumes: the table is written before sampling starts. A read of an address
// written in the same cycle returns the old contents.
module icdf_coef_ram #(
    parameter int ADDR_W = 9,
    parameter int C0_W   = 46,
    parameter int C1_W   = 23
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [C0_W-1:0]   wr_off,
    input  logic [C1_W-1:0]   wr_slope,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [C0_W-1:0]   rd_off,
    output logic [C1_W-1:0]   rd_slope
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int WORD_W = C0_W + C1_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_word;

    // Write port: store the coefficient pair when enabled.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= {wr_off, wr_slope};
        end
    end

    // Read port: register the addressed pair (stage 1 of the pipeline).
    always_ff @(posedge clk) begin
        rd_word <= mem[rd_addr];
    end

    assign rd_off   = rd_word[WORD_W-1:C1_W];
    assign rd_slope = rd_word[C1_W-1:0];
endmodule

// File: rtl/icdf_mac.sv
// Module: icdf_mac
// Two registered stages: a signed slope times an unsigned operand, then an
// add of the sign-extended offset.
// Assumes: ACC_W covers both the offset and the full product width.
module icdf_mac #(
    parameter int C0_W  = 46,
    parameter int C1_W  = 23,
    parameter int X_W   = 17,
    parameter int ACC_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_i,
    input  logic                    neg_i,
    input  logic signed [C0_W-1:0]  off_i,
    input  logic signed [C1_W-1:0]  slope_i,
    input  logic [X_W-1:0]          x_i,
    output logic                    vld_o,
    output logic                    neg_o,
    output logic [ACC_W-1:0]        acc_o
);
    localparam int PROD_W = C1_W + X_W + 1;

    logic signed [X_W:0]      x_ext;
    logic signed [PROD_W-1:0] prod_q;
    logic [C0_W-1:0]          off_q;
    logic                     vld_q;
    logic                     neg_q;

    assign x_ext = {1'b0, x_i};

    // Stage 2: product and the offset carried alongside it.
    always_ff @(posedge clk) begin
        prod_q <= slope_i * x_ext;
        off_q  <= off_i;
    end

    // Stage 2 control: valid and half bit move with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            neg_q <= 1'b0;
        end else begin
            vld_q <= vld_i;
            neg_q <= neg_i;
        end
    end

    // Stage 3: accumulate the sign-extended offset and product.
    always_ff @(posedge clk) begin
        acc_o <= {{(ACC_W-C0_W){off_q[C0_W-1]}}, off_q}
               + {{(ACC_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};
    end

    // Stage 3 control: valid and half bit move with the sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            neg_o <= 1'b0;
        end else begin
            vld_o <= vld_q;
            neg_o <= neg_q;
        end
    end
endmodule

// File: rtl/icdf_sign_out.sv
// Module: icdf_sign_out
// Final stage: takes the fixed-point window of the sum, negates it for the
// upper half and zeroes the output when nothing is valid.
// Assumes: FRAC_SHIFT + OUT_W <= ACC_W.
module icdf_sign_out #(
    parameter int ACC_W      = 48,
    parameter int OUT_W      = 24,
    parameter int FRAC_SHIFT = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             neg_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic             vld_o,
    output logic [OUT_W-1:0] y_o
);
    logic [OUT_W-1:0] field;
    logic             acc_unused;

    generate
        if (FRAC_SHIFT + OUT_W <= ACC_W) begin : g_window
            assign field = acc_i[FRAC_SHIFT +: OUT_W];
        end else begin : g_narrow
            assign field = OUT_W'(acc_i >> FRAC_SHIFT);
        end
    endgenerate

    // Bits outside the window are dropped on purpose.
    assign acc_unused = ^acc_i;

    // Stage 4: register the signed result, or zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            y_o   <= '0;
        end else begin
            vld_o <= vld_i;
            if (!vld_i) begin
                y_o <= '0;
            end else if (neg_i) begin
                y_o <= '0 - field;
            end else begin
                y_o <= field;
            end
        end
    end
endmodule

// File: rtl/icdf_interp.sv
// Module: icdf_interp (top)
// Maps a split floating-point uniform sample to a Gaussian fixed-point value.
// It uses a segment/subsegment coefficient table and linear interpolation,
// with a latency of four edges and one sample per cycle.
// Assumes: the table is loaded before sampling and the consumer never stalls.
module icdf_interp #(
    parameter int EXP_W      = 6,
    parameter int MANT_W     = 20,
    parameter int SUB_W      = icdf_pkg::SUBSEG_BITS,
    parameter int C0_W       = 46,
    parameter int C1_W       = 23,
    parameter int ACC_W      = 48,
    parameter int OUT_W      = 24,
    parameter int FRAC_SHIFT = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_we,
    input  logic [EXP_W+SUB_W-1:0]   ld_addr,
    input  logic [C0_W-1:0]          ld_off,
    input  logic [C1_W-1:0]          ld_slope,
    input  logic                     in_valid,
    input  logic                     in_neg,
    input  logic [EXP_W-1:0]         in_exp,
    input  logic [MANT_W-1:0]        in_mant,
    output logic                     out_valid,
    output logic [OUT_W-1:0]         out_y
);
    localparam int ADDR_W = EXP_W + SUB_W;
    localparam int X_W    = MANT_W - SUB_W;

    logic [ADDR_W-1:0] rd_addr;
    logic [C0_W-1:0]   s1_off;
    logic [C1_W-1:0]   s1_slope;
    logic [X_W-1:0]    s1_x;
    logic              s1_vld;
    logic              s1_neg;
    logic              s3_vld;
    logic              s3_neg;
    logic [ACC_W-1:0]  s3_acc;

    // The exponent sits above the subsegment bits, so no shifter is needed.
    assign rd_addr = {in_exp, in_mant[MANT_W-1 -: SUB_W]};

    icdf_coef_ram #(.ADDR_W(ADDR_W), .C0_W(C0_W), .C1_W(C1_W)) u_ram (
        .clk      (clk),
        .wr_en    (ld_we),
        .wr_addr  (ld_addr),
        .wr_off   (ld_off),
        .wr_slope (ld_slope),
        .rd_addr  (rd_addr),
        .rd_off   (s1_off),
        .rd_slope (s1_slope)
    );

    // Stage 1 side path: interpolation operand, matched to the table read.
    always_ff @(posedge clk) begin
        s1_x <= in_mant[X_W-1:0];
    end

    // Stage 1 control: valid and half bit matched to the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_neg <= 1'b0;
        end else begin
            s1_vld <= in_valid;
            s1_neg <= in_neg;
        end
    end

    icdf_mac #(.C0_W(C0_W), .C1_W(C1_W), .X_W(X_W), .ACC_W(ACC_W)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (s1_vld),
        .neg_i   (s1_neg),
        .off_i   (s1_off),
        .slope_i (s1_slope),
        .x_i     (s1_x),
        .vld_o   (s3_vld),
        .neg_o   (s3_neg),
        .acc_o   (s3_acc)
    );

    icdf_sign_out #(.ACC_W(ACC_W), .OUT_W(OUT_W), .FRAC_SHIFT(FRAC_SHIFT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (s3_vld),
        .neg_i (s3_neg),
        .acc_i (s3_acc),
        .vld_o (out_valid),
        .y_o   (out_y)
    );
endmodule

// File: rtl/icdf_interp_chk.sv
// Module: icdf_interp_chk
// Assertion checker bound to icdf_interp. It follows in_valid through a
// shift register as deep as the pipeline and checks the output handshake
// and the output values.
// Assumes: the fixed latency from icdf_pkg.
module icdf_interp_chk #(
    parameter int ADDR_W = 9,
    parameter int C0_W   = 46,
    parameter int C1_W   = 23,
    parameter int OUT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_we,
    input logic [ADDR_W-1:0] ld_addr,
    input logic [C0_W-1:0]   ld_off,
    input logic [C1_W-1:0]   ld_slope,
    input logic              in_valid,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_y
);
    localparam int LAT = icdf_pkg::LATENCY;

    logic [LAT-1:0] vpipe;

    // Delayed copy of in_valid, one bit per pipeline edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpipe <= '0;
        end else begin
            vpipe <= {vpipe[LAT-2:0], in_valid};
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_y == '0));

    a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vpipe[LAT-1]);

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_y == '0);

    a_r7_known_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_y));

    a_r8_load_known: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> !$isunknown({ld_addr, ld_off, ld_slope}));
endmodule

bind icdf_interp icdf_interp_chk #(
    .ADDR_W (EXP_W + SUB_W),
    .C0_W   (C0_W),
    .C1_W   (C1_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_we     (ld_we),
    .ld_addr   (ld_addr),
    .ld_off    (ld_off),
    .ld_slope  (ld_slope),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_y     (out_y)
);

// File: tb/sim_icdf_interp.sv
`timescale 1ns/1ps
// Bench for icdf_interp: loads the table, streams a vector table,
// then runs directed tests for reset, load, sign and latency.
module sim_icdf_interp;
    localparam int EXP_W = 6, MANT_W = 20, C0_W = 46, C1_W = 23;
    localparam int ACC_W = 48, OUT_W = 24, FRAC_SHIFT = 20;
    localparam int ADDR_W = EXP_W + 3, X_W = MANT_W - 3;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NVEC = 12;
    // Each entry: {neg, exp, mant}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 6'd0,  20'h00000}, {1'b1, 6'd0,  20'h00000},
        {1'b0, 6'd63, 20'hFFFFF}, {1'b1, 6'd63, 20'hFFFFF},
        {1'b0, 6'd1,  20'h20000}, {1'b0, 6'd1,  20'h3FFFF},
        {1'b0, 6'd17, 20'hA5A5A}, {1'b1, 6'd17, 20'hA5A5A},
        {1'b0, 6'd40, 20'h1FFFF}, {1'b0, 6'd40, 20'hE0001},
        {1'b1, 6'd5,  20'h7C3E1}, {1'b0, 6'd62, 20'h40000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_we = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [C0_W-1:0] ld_off = '0;
    logic [C1_W-1:0] ld_slope = '0;
    logic in_valid = 1'b0, in_neg = 1'b0;
    logic [EXP_W-1:0] in_exp = '0;
    logic [MANT_W-1:0] in_mant = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_y;

    logic [C0_W-1:0] tb_off [DEPTH];
    logic [C1_W-1:0] tb_slope [DEPTH];
    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    icdf_interp u0 (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_off(ld_off), .ld_slope(ld_slope), .in_valid(in_valid),
        .in_neg(in_neg), .in_exp(in_exp), .in_mant(in_mant),
        .out_valid(out_valid), .out_y(out_y)
    );

    // Expected result from the requirement formula (R2, R3, R4, R5).
    function automatic logic [OUT_W-1:0] ref_y(logic neg, logic [EXP_W-1:0] e,
                                               logic [MANT_W-1:0] m);
        logic [ADDR_W-1:0] a;
        logic signed [ACC_W-1:0] off_s, sl_s, acc;
        logic [OUT_W-1:0] f;
        a = {e, m[MANT_W-1 -: 3]};
        off_s = ACC_W'($signed(tb_off[a]));
        sl_s = ACC_W'($signed(tb_slope[a]));
        acc = off_s + sl_s * $signed({{(ACC_W-X_W){1'b0}}, m[X_W-1:0]});
        f = acc[FRAC_SHIFT +: OUT_W];
        return neg ? ('0 - f) : f;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(int a, logic [C0_W-1:0] o, logic [C1_W-1:0] s);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = ADDR_W'(a); ld_off = o; ld_slope = s;
        tb_off[a] = o; tb_slope[a] = s;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // One isolated sample; checks early, on-time and late cycles (R6, R9).
    task automatic sample(logic n, logic [EXP_W-1:0] e, logic [MANT_W-1:0] m,
                          string req, output logic [OUT_W-1:0] got);
        logic [OUT_W-1:0] exp_y;
        exp_y = ref_y(n, e, m);
        @(negedge clk);
        in_valid = 1'b1; in_neg = n; in_exp = e; in_mant = m;
        @(negedge clk);
        in_valid = 1'b0; in_mant = ~m; in_neg = ~n;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R6 early valid", longint'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R6 valid on time", longint'(out_valid), 1);
        check(out_y == exp_y, req, longint'(out_y), longint'(exp_y));
        got = out_y;
        @(negedge clk);
        check(out_valid == 1'b0 && out_y == '0, "R9 idle zero",
              longint'(out_y), 0);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [OUT_W-1:0] ya, yb;
        repeat (3) @(negedge clk);
        // R1: outputs clear under reset and on the first cycle after it.
        check(out_valid == 1'b0 && out_y == '0, "R1 in reset", longint'(out_y), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_y == '0, "R1 after reset", longint'(out_y), 0);

        // Fill the table with mixed-sign offsets and slopes (R4).
        for (int a = 0; a < DEPTH; a++) begin
            longint ov, sv;
            ov = (longint'((a * 7919) % 100003) - 50000) <<< 16;
            sv = (longint'((a * 613) % 8191) - 4096) <<< 8;
            load(a, C0_W'(ov), C1_W'(sv));
        end

        // R7: stream the vector table back to back; check in order.
        for (int i = 0; i < NVEC + 4; i++) begin
            @(negedge clk);
            if (i >= 4) begin
                logic [26:0] v;
                logic [OUT_W-1:0] e;
                v = VEC[i-4];
                e = ref_y(v[26], v[25:20], v[19:0]);
                check(out_valid == 1'b1, "R7 stream valid", longint'(out_valid), 1);
                check(out_y == e, "R7 R3 stream value", longint'(out_y), longint'(e));
            end
            if (i < NVEC) begin
                in_valid = 1'b1;
                {in_neg, in_exp, in_mant} = VEC[i];
            end else begin
                in_valid = 1'b0;
            end
        end

        // R2: both ends of the address space.
        sample(1'b0, 6'd0, 20'h0_0000, "R2 address 0", ya);
        sample(1'b0, 6'd63, 20'hE_1234, "R2 address 511", ya);
        // R3: zero operand gives the offset alone; full operand.
        sample(1'b0, 6'd9, 20'h6_0000, "R3 x zero", ya);
        sample(1'b0, 6'd9, 20'h7_FFFF, "R3 x max", ya);

        // R4: negative slope, result falls as x grows.
        load(300, C0_W'(64'sd1 <<< 30), C1_W'(-64'sd4096));
        sample(1'b0, 6'd37, 20'h8_0000, "R4 neg slope x0", ya);
        sample(1'b0, 6'd37, 20'h9_FFFF, "R4 neg slope xmax", yb);
        check($signed(yb) < $signed(ya), "R4 decreasing", longint'(yb), longint'(ya));

        // R5: exact two's complement mirror, with a truncated fraction.
        load(77, C0_W'(64'sd3 <<< 19), C1_W'(64'sd5));
        sample(1'b0, 6'd9, 20'hA_0003, "R5 positive half", ya);
        sample(1'b1, 6'd9, 20'hA_0003, "R5 negative half", yb);
        check(yb == ('0 - ya), "R5 mirror", longint'(yb), longint'('0 - ya));

        // R8: a disabled write leaves the entry alone.
        @(negedge clk);
        ld_we = 1'b0; ld_addr = 9'd5; ld_off = '1; ld_slope = '1;
        @(negedge clk);
        sample(1'b0, 6'd0, 20'hB_1111, "R8 no write when disabled", ya);
        // R8: an enabled write takes effect.
        load(5, C0_W'(-64'sd7 <<< 24), C1_W'(64'sd1234));
        sample(1'b0, 6'd0, 20'hB_1111, "R8 write takes effect", ya);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule